// File: doc/BRIEF.md
# Indirect Video Memory Access Port

This block lets a CPU reach a word-addressed video memory that does not appear in the CPU address space. The CPU sees three 16-bit registers: an address pointer, a data window and a signed step. A data write is posted into a one-entry buffer and committed in the next CPU slot. After the commit, the step is added to the pointer. Loading the pointer starts a prefetch into a read latch, and reading the data window returns that latch.

The single-ported store is shared with a video renderer through a fixed slot rotation. One phase in every `SLOT_DIV` cycles belongs to the CPU side, and every other phase belongs to the renderer. Address bit 15 selects between a lower zone and an upper zone. The pointer step wraps inside bits 14:0 only, so software must load the pointer explicitly to move between the zones.

Top module: `vidmem_port`

## Requirements
- R1: Reset sets the pointer and the step to 0, empties the posted-write buffer and clears the read latch, so all three registers read back 0.
- R2: `cpu_reg` selects the register: 0 is the pointer, 1 is the data window and 2 is the step. A read returns the pointer, the read latch or the step. Selector 3 reads 0, and writes to it change nothing.
- R3: A data write stores the word at the pointer value that held when the write was accepted.
- R4: After a data write commits, the pointer becomes pointer + step in two's complement. The step 0xFFFE moves the pointer back by 2.
- R5: Reading any register never changes the pointer.
- R6: The step addition never changes bit 15. With step 1, 0x7FFF becomes 0x0000. With step 0xFFFF, 0x8000 becomes 0xFFFF.
- R7: A data read made 16 or more cycles after a pointer load returns the word stored at the new pointer.
- R8: A renderer request is served only in non-CPU phases. `rnd_valid` is high in the cycle after a grant, and it carries the stored word. A request is served within 2 cycles at `SLOT_DIV`=4.
- R9: In the upper zone, a word sits at index addr[HI_AW-1:0]; with the default of 11, 0x8800 aliases 0x8000. In the lower zone, a word sits at addr[LO_AW-1:0]; with the default of 10, 0x7FFF aliases 0x03FF.
- R10: Data writes spaced 12 cycles apart all land, even while the renderer requests every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_sel | input | 1 | CPU register access strobe |
| cpu_we | input | 1 | High for a write, low for a read |
| cpu_reg | input | 2 | Register selector |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for the selected register |
| rnd_req | input | 1 | Renderer read request |
| rnd_addr | input | 16 | Renderer word address |
| rnd_slot | output | 1 | High in renderer phases |
| rnd_valid | output | 1 | Renderer data valid |
| rnd_rdata | output | 16 | Renderer read data |

## Verification
The bench loads the pointer at 0x7FFF and at 0x8000 and steps past each edge. A design that let the carry or borrow reach bit 15 would read back 0x8000 or 0x7FFF instead of wrapping. A negative step is also exercised; a design that treated the step as unsigned, or that advanced the pointer on reads, would show a wrong pointer on readback. Reads at 0x8800 and 0x03FF catch any index mapping that fails to alias. Posted writes spaced 12 cycles apart are issued while the renderer requests every cycle, so a design that starved the CPU slot or dropped buffered data would lose stored words.

// File: rtl/vidmem_pkg.sv
package vidmem_pkg;
   localparam int unsigned WORD_W = 16;

   typedef enum logic [1:0] {
      SEL_PTR  = 2'd0,
      SEL_DATA = 2'd1,
      SEL_STEP = 2'd2,
      SEL_NONE = 2'd3
   } vm_sel_e;

   // add step inside bits 14:0, keep zone bit
   function automatic logic [15:0] zone_step(input logic [15:0] a, input logic [15:0] s);
      logic [14:0] low;
      low = a[14:0] + s[14:0];
      return {a[15], low};
   endfunction
endpackage

// File: rtl/vidmem_regs.sv
module vidmem_regs
   import vidmem_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        cpu_sel,
   input  logic        cpu_we,
   input  logic [1:0]  cpu_reg,
   input  logic [15:0] cpu_wdata,
   output logic [15:0] cpu_rdata,
   input  logic        wr_grant,
   input  logic        rd_grant,
   input  logic        rd_done,
   input  logic [15:0] store_q,
   output logic [15:0] ptr,
   output logic [15:0] step,
   output logic        wb_valid,
   output logic [15:0] wb_addr,
   output logic [15:0] wb_data,
   output logic        pf_pend
);
   logic [15:0] rd_latch;
   logic        ld_ptr, ld_data, ld_step;

   assign ld_ptr  = cpu_sel && cpu_we && (cpu_reg == SEL_PTR);
   assign ld_data = cpu_sel && cpu_we && (cpu_reg == SEL_DATA);
   assign ld_step = cpu_sel && cpu_we && (cpu_reg == SEL_STEP);

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr  <= '0;
         step <= '0;
      end else begin
         if (ld_ptr)
            ptr <= cpu_wdata;
         else if (wr_grant)
            ptr <= zone_step(wb_addr, step);
         if (ld_step)
            step <= cpu_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wb_valid <= 1'b0;
         wb_addr  <= '0;
         wb_data  <= '0;
      end else if (ld_data) begin
         wb_valid <= 1'b1;
         wb_addr  <= ptr;
         wb_data  <= cpu_wdata;
      end else if (wr_grant) begin
         wb_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pf_pend  <= 1'b0;
         rd_latch <= '0;
      end else begin
         if (ld_ptr)
            pf_pend <= 1'b1;
         else if (rd_grant)
            pf_pend <= 1'b0;
         if (rd_done)
            rd_latch <= store_q;
      end
   end

   always_comb begin
      unique case (vm_sel_e'(cpu_reg))
         SEL_PTR:  cpu_rdata = ptr;
         SEL_DATA: cpu_rdata = rd_latch;
         SEL_STEP: cpu_rdata = step;
         default:  cpu_rdata = '0;
      endcase
   end
endmodule

// File: rtl/vidmem_slot_arb.sv
module vidmem_slot_arb #(
   parameter int unsigned SLOT_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic wb_valid,
   input  logic pf_pend,
   input  logic rnd_req,
   output logic cpu_slot,
   output logic wr_grant,
   output logic rd_grant,
   output logic rnd_grant,
   output logic rd_done,
   output logic rnd_valid
);
   localparam int unsigned PW = (SLOT_DIV > 2) ? $clog2(SLOT_DIV) : 1;

   generate
      if (SLOT_DIV == 2) begin : g_toggle
         logic ph;
         always_ff @(posedge clk) begin
            if (rst) ph <= 1'b0;
            else     ph <= ~ph;
         end
         assign cpu_slot = ~ph;
      end else begin : g_count
         logic [PW-1:0] ph;
         always_ff @(posedge clk) begin
            if (rst)                          ph <= '0;
            else if (ph == PW'(SLOT_DIV - 1)) ph <= '0;
            else                              ph <= ph + 1'b1;
         end
         assign cpu_slot = (ph == '0);
      end
   endgenerate

   assign wr_grant  = cpu_slot && wb_valid;
   assign rd_grant  = cpu_slot && !wb_valid && pf_pend;
   assign rnd_grant = !cpu_slot && rnd_req;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_done   <= 1'b0;
         rnd_valid <= 1'b0;
      end else begin
         rd_done   <= rd_grant;
         rnd_valid <= rnd_grant;
      end
   end
endmodule

// File: rtl/vidmem_store.sv
module vidmem_store #(
   parameter int unsigned LO_AW = 10,
   parameter int unsigned HI_AW = 11
) (
   input  logic        clk,
   input  logic        en,
   input  logic        we,
   input  logic [15:0] addr,
   input  logic [15:0] wdata,
   output logic [15:0] q
);
   localparam int unsigned LO_DEPTH = 1 << LO_AW;
   localparam int unsigned HI_DEPTH = 1 << HI_AW;
   localparam int unsigned DEPTH    = LO_DEPTH + HI_DEPTH;
   localparam int unsigned IW       = $clog2(DEPTH);

   logic [15:0] mem [DEPTH];
   logic [IW-1:0] idx;

   always_comb begin
      if (addr[15]) idx = IW'(LO_DEPTH) + IW'(addr[HI_AW-1:0]);
      else          idx = IW'(addr[LO_AW-1:0]);
   end

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[idx] <= wdata;
         q <= mem[idx];
      end
   end
endmodule

// File: rtl/vidmem_port.sv
module vidmem_port
   import vidmem_pkg::*;
#(
   parameter int unsigned LO_AW    = 10,
   parameter int unsigned HI_AW    = 11,
   parameter int unsigned SLOT_DIV = 4
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        cpu_sel,
   input  logic        cpu_we,
   input  logic [1:0]  cpu_reg,
   input  logic [15:0] cpu_wdata,
   output logic [15:0] cpu_rdata,
   input  logic        rnd_req,
   input  logic [15:0] rnd_addr,
   output logic        rnd_slot,
   output logic        rnd_valid,
   output logic [15:0] rnd_rdata
);
   generate
      if (LO_AW < 1 || LO_AW > 15) begin : g_bad_lo
         $error("LO_AW must lie in 1..15");
      end
      if (HI_AW < 1 || HI_AW > 15) begin : g_bad_hi
         $error("HI_AW must lie in 1..15");
      end
      if (SLOT_DIV < 2 || SLOT_DIV > 8) begin : g_bad_div
         $error("SLOT_DIV must lie in 2..8 to meet write spacing");
      end
   endgenerate

   logic        cpu_slot, wr_grant, rd_grant, rnd_grant, rd_done;
   logic        wb_valid, pf_pend;
   logic [15:0] ptr, step, wb_addr, wb_data, store_q, port_addr;

   vidmem_regs u_regs (
      .clk, .rst, .cpu_sel, .cpu_we, .cpu_reg, .cpu_wdata, .cpu_rdata,
      .wr_grant, .rd_grant, .rd_done, .store_q,
      .ptr, .step, .wb_valid, .wb_addr, .wb_data, .pf_pend
   );

   vidmem_slot_arb #(.SLOT_DIV(SLOT_DIV)) u_arb (
      .clk, .rst, .wb_valid, .pf_pend, .rnd_req,
      .cpu_slot, .wr_grant, .rd_grant, .rnd_grant, .rd_done, .rnd_valid
   );

   always_comb begin
      if (wr_grant)      port_addr = wb_addr;
      else if (rd_grant) port_addr = ptr;
      else               port_addr = rnd_addr;
   end

   vidmem_store #(.LO_AW(LO_AW), .HI_AW(HI_AW)) u_store (
      .clk,
      .en   (wr_grant || rd_grant || rnd_grant),
      .we   (wr_grant),
      .addr (port_addr),
      .wdata(wb_data),
      .q    (store_q)
   );

   assign rnd_slot  = !cpu_slot;
   assign rnd_rdata = store_q;
endmodule

// File: rtl/vidmem_port_chk.sv
module vidmem_port_chk (
   input logic        clk,
   input logic        rst,
   input logic        cpu_sel,
   input logic        cpu_we,
   input logic [1:0]  cpu_reg,
   input logic        cpu_slot,
   input logic        wr_grant,
   input logic        rd_grant,
   input logic        rnd_grant,
   input logic        rnd_valid,
   input logic        wb_valid,
   input logic [15:0] wb_addr,
   input logic [15:0] ptr
);
   logic ptr_load, data_load;
   assign ptr_load  = cpu_sel && cpu_we && (cpu_reg == 2'd0);
   assign data_load = cpu_sel && cpu_we && (cpu_reg == 2'd1);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (ptr == 16'h0000) && !wb_valid);

   // R8
   one_owner_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({wr_grant, rd_grant, rnd_grant}));

   // R8
   rnd_phase_chk: assert property (@(posedge clk) disable iff (rst)
      rnd_grant |-> !cpu_slot);

   // R8
   rnd_valid_chk: assert property (@(posedge clk) disable iff (rst)
      rnd_grant |=> rnd_valid);

   // R6
   zone_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_grant && !ptr_load) |=> (ptr[15] == $past(wb_addr[15])));

   // R3
   post_drain_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_slot && wb_valid && !data_load) |=> !wb_valid);

   // R5
   ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!wr_grant && !ptr_load) |=> $stable(ptr));
endmodule

bind vidmem_port vidmem_port_chk u_chk (
   .clk, .rst, .cpu_sel, .cpu_we, .cpu_reg,
   .cpu_slot, .wr_grant, .rd_grant, .rnd_grant, .rnd_valid,
   .wb_valid, .wb_addr, .ptr
);

// File: tb/vidmem_port_test.sv
module vidmem_port_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_sel = 1'b0, cpu_we = 1'b0;
   logic [1:0]  cpu_reg = 2'd0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic        rnd_req = 1'b0;
   logic [15:0] rnd_addr = '0;
   logic        rnd_slot, rnd_valid;
   logic [15:0] rnd_rdata;

   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   vidmem_port uut (.*);

   localparam logic [1:0] OW = 2'd0, OR = 2'd1;
   localparam logic [1:0] SP = 2'd0, SD = 2'd1, SS = 2'd2, SN = 2'd3;
   // fields: op, reg, data, expected, requirement number
   localparam int NV = 33;
   localparam logic [39:0] VEC [NV] = '{
      {OW, SS, 16'h0001, 16'h0000, 4'd4},
      {OW, SP, 16'h0010, 16'h0000, 4'd4},
      {OW, SD, 16'h1111, 16'h0000, 4'd3},
      {OW, SD, 16'h2222, 16'h0000, 4'd3},
      {OR, SP, 16'h0000, 16'h0012, 4'd4},   // R4 two commits of +1
      {OW, SP, 16'h0010, 16'h0000, 4'd7},
      {OR, SD, 16'h0000, 16'h1111, 4'd7},   // R7 prefetch, R3 stored word
      {OW, SP, 16'h0011, 16'h0000, 4'd7},
      {OR, SD, 16'h0000, 16'h2222, 4'd3},   // R3
      {OR, SD, 16'h0000, 16'h2222, 4'd5},
      {OR, SP, 16'h0000, 16'h0011, 4'd5},   // R5 reads leave pointer
      {OW, SS, 16'hFFFE, 16'h0000, 4'd4},
      {OW, SP, 16'h0020, 16'h0000, 4'd4},
      {OW, SD, 16'hAAAA, 16'h0000, 4'd4},
      {OR, SP, 16'h0000, 16'h001E, 4'd4},   // R4 negative step
      {OW, SS, 16'h0001, 16'h0000, 4'd6},
      {OW, SP, 16'h7FFF, 16'h0000, 4'd6},
      {OW, SD, 16'h3333, 16'h0000, 4'd6},
      {OR, SP, 16'h0000, 16'h0000, 4'd6},   // R6 no carry into bit 15
      {OW, SS, 16'hFFFF, 16'h0000, 4'd6},
      {OW, SP, 16'h8000, 16'h0000, 4'd6},
      {OW, SD, 16'h4444, 16'h0000, 4'd6},
      {OR, SP, 16'h0000, 16'hFFFF, 4'd6},   // R6 no borrow out of bit 15
      {OW, SP, 16'h8800, 16'h0000, 4'd9},
      {OR, SD, 16'h0000, 16'h4444, 4'd9},   // R9 upper alias
      {OW, SP, 16'h03FF, 16'h0000, 4'd9},
      {OR, SD, 16'h0000, 16'h3333, 4'd9},   // R9 lower alias
      {OW, SN, 16'h5555, 16'h0000, 4'd2},
      {OR, SN, 16'h0000, 16'h0000, 4'd2},   // R2 selector 3
      {OR, SP, 16'h0000, 16'h03FF, 4'd2},
      {OR, SS, 16'h0000, 16'hFFFF, 4'd2},
      {OW, SP, 16'h0020, 16'h0000, 4'd4},
      {OR, SD, 16'h0000, 16'hAAAA, 4'd4}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] r, input logic [15:0] d);
      @(negedge clk);
      cpu_sel = 1'b1; cpu_we = 1'b1; cpu_reg = r; cpu_wdata = d;
      @(negedge clk);
      cpu_sel = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] r, output logic [15:0] d);
      @(negedge clk);
      cpu_sel = 1'b1; cpu_we = 1'b0; cpu_reg = r;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rnd_read(input string req, input logic [15:0] a, input logic [15:0] exp);
      int waited;
      logic got;
      @(negedge clk);
      rnd_req = 1'b1; rnd_addr = a;
      waited = 0; got = 1'b0;
      while (!got && waited < 8) begin
         @(negedge clk);
         waited++;
         if (rnd_valid) got = 1'b1;
      end
      rnd_req = 1'b0;
      check(req, {15'd0, got && (waited <= 2)}, 16'h0001);
      check(req, rnd_rdata, exp);
   endtask

   initial begin
      logic [15:0] v;
      idle(3);
      rst = 1'b0;
      idle(2);
      // R1 reset state
      rd(SP, v); check("R1", v, 16'h0000);
      rd(SS, v); check("R1", v, 16'h0000);
      rd(SD, v); check("R1", v, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][39:38] == OW) begin
            wr(VEC[i][37:36], VEC[i][35:20]);
         end else begin
            rd(VEC[i][37:36], v);
            check($sformatf("R%0d", VEC[i][3:0]), v, VEC[i][19:4]);
         end
         idle(16);
      end

      // R8 renderer reads of stored words
      rnd_read("R8", 16'h0010, 16'h1111);
      rnd_read("R8", 16'h8000, 16'h4444);
      rnd_read("R9", 16'h8800, 16'h4444);

      // R10 writes 12 cycles apart under constant renderer load
      wr(SS, 16'h0001); idle(16);
      wr(SP, 16'h0100); idle(16);
      rnd_req = 1'b1; rnd_addr = 16'h0010;
      for (int k = 0; k < 4; k++) begin
         wr(SD, 16'hB000 + 16'(k));
         idle(10);
      end
      idle(16);
      rnd_req = 1'b0;
      rd(SP, v); check("R10", v, 16'h0104);
      for (int k = 0; k < 4; k++) begin
         wr(SP, 16'h0100 + 16'(k)); idle(16);
         rd(SD, v); check("R10", v, 16'hB000 + 16'(k));
      end

      // R1 reset mid-run clears registers
      rst = 1'b1; idle(2); rst = 1'b0; idle(2);
      rd(SP, v); check("R1", v, 16'h0000);
      rd(SS, v); check("R1", v, 16'h0000);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule